// File: doc/BRIEF.md
# Line and Sample Strobe Pacer

This block paces a group of external data sources from one system clock. It drives a square-wave data strobe with a period of one microsecond and a duty of one half. It also drives a line window that stays open for the first 256 strobe periods of every 1000-period (1 ms) frame. The frames follow one another with no gap. Both strobes are derived by counters from a single frame position, so the window edges always line up with strobe rising edges.

The sources change their data when the data strobe falls. The capture side takes each value on the next rising edge. For the capture side, the block gives a one-cycle sample pulse on every data-strobe rising edge that falls inside the window. With the pulse comes a sample index that counts the samples taken so far in the current line. One cycle after the last sample of a line, a line-done pulse is given. The strobe timing is set by three parameters:
- the number of system cycles in half a strobe period;
- the number of strobe periods per frame;
- the number of samples per line.

Top module: `line_pacer`

## Requirements
- R1: `data_strobe` is a square wave whose period is 2*HALF_CYC system cycles. It is high for the first HALF_CYC cycles of each period and low for the next HALF_CYC cycles. Its first high cycle is the first clock after reset is released.
- R2: `line_window` is high for the first SAMPLES strobe periods of each frame and low for the remaining PERIODS-SAMPLES periods. It rises only in the same cycle as `data_strobe` rises.
- R3: Frames of PERIODS strobe periods repeat without end. Each frame carries exactly SAMPLES sample pulses.
- R4: `sample_pulse` is high for exactly one cycle at each rising edge of `data_strobe`, that is, in the first high cycle of the strobe. It does this only while `line_window` is high and never at any other time. A sample is therefore taken one half period after the falling edge on which the sources launch their data.
- R5: `sample_idx` is 0 at the start of each window. It shows the value k (k = 0 ... SAMPLES-1) during the k-th sample pulse of the line and increments by one in the cycle after each pulse.
- R6: `line_done` is high for exactly one cycle, the cycle right after the pulse with index SAMPLES-1. In that same cycle `sample_idx` returns to 0.
- R7: While `rst_n` is low, all outputs are 0.
- R8: Asserting `rst_n` low at any point, even in the middle of a frame, clears all outputs at once, without waiting for a clock edge. After release, a new frame starts at frame position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, release is expected synchronous to clk |
| data_strobe | output | 1 | Data strobe square wave to the sources |
| line_window | output | 1 | Line window, open for SAMPLES periods per frame |
| sample_pulse | output | 1 | One-cycle capture enable at each in-window strobe rising edge |
| sample_idx | output | IDX_W | Sample index within the line |
| line_done | output | 1 | One-cycle pulse after the last sample of a line |

## Verification
Every output is registered one stage after the frame counters. As a result, the state that the counters hold at frame position t is seen at the ports in the cycle after the t-th clock edge since reset release. Because it is registered from the pulse, `line_done` and the index step appear one cycle later still. The bench counts clock edges since reset release and from that count works out the frame position, strobe level, window, pulse, index and done values. It compares them on the falling clock edge of every cycle, so every sample lands between two active edges. Reset is also asserted in the middle of a frame: the outputs are checked right away, before any clock edge, and the sweep then restarts from position 0.

// File: rtl/lp_pkg.sv
package lp_pkg;
  // strobe half selector: first half of a period drives the strobe high
  typedef enum logic {HALF_HI = 1'b0, HALF_LO = 1'b1} half_e;
endpackage

// File: rtl/lp_phase.sv
module lp_phase #(
  parameter int HALF_CYC = 5,
  parameter int PH_W     = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic high_o,
  output logic rise_o,
  output logic period_end_o
);
  import lp_pkg::*;

  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF_CYC - 1);

  logic [PH_W-1:0] ph_q, ph_d;
  half_e           hb_q, hb_d;

  always_comb begin
    ph_d = ph_q;
    hb_d = hb_q;
    if (ph_q == PH_LAST) begin
      ph_d = '0;
      hb_d = (hb_q == HALF_HI) ? HALF_LO : HALF_HI;
    end else begin
      ph_d = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
      hb_q <= HALF_HI;
    end else begin
      ph_q <= ph_d;
      hb_q <= hb_d;
    end
  end

  assign high_o       = (hb_q == HALF_HI);
  assign rise_o       = (ph_q == '0) && (hb_q == HALF_HI);
  assign period_end_o = (ph_q == PH_LAST) && (hb_q == HALF_LO);

  // R1: the half selector may only flip when the phase counter restarts
  a_r1_half_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != '0) |-> $stable(hb_q));
endmodule

// File: rtl/lp_frame.sv
module lp_frame #(
  parameter int PERIODS = 1000,
  parameter int SAMPLES = 256,
  parameter int PER_W   = $clog2(PERIODS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  output logic in_win_o
);
  localparam logic [PER_W-1:0] PER_LAST = PER_W'(PERIODS - 1);
  localparam logic [PER_W-1:0] WIN_LEN  = PER_W'(SAMPLES);

  logic [PER_W-1:0] per_q, per_d;
  logic             per_en;

  assign per_en = step_i;

  always_comb begin
    per_d = per_q;
    if (per_en) begin
      if (per_q == PER_LAST) per_d = '0;
      else                   per_d = per_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) per_q <= '0;
    else        per_q <= per_d;
  end

  assign in_win_o = (per_q < WIN_LEN);

  // R3: after the last period of a frame the count starts over at zero
  a_r3_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && per_q == PER_LAST) |=> (per_q == '0));
endmodule

// File: rtl/lp_sampler.sv
module lp_sampler #(
  parameter int SAMPLES = 256,
  parameter int IDX_W   = $clog2(SAMPLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  output logic             sample_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SAMPLES - 1);

  logic             smp_q, smp_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;

  always_comb begin
    smp_d  = take_i;
    idx_d  = idx_q;
    done_d = 1'b0;
    if (smp_q) begin
      if (idx_q == IDX_LAST) begin
        idx_d  = '0;
        done_d = 1'b1;
      end else begin
        idx_d  = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      smp_q  <= smp_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  assign sample_o = smp_q;
  assign idx_o    = idx_q;
  assign done_o   = done_q;

  // R5: each non-final sample advances the index by exactly one
  a_r5_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_q && idx_q != IDX_LAST) |=> (idx_q == $past(idx_q) + 1'b1));
  // R6: done follows only the final sample, and the index restarts with it
  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(smp_q) && $past(idx_q) == IDX_LAST && idx_q == '0));
endmodule

// File: rtl/line_pacer.sv
module line_pacer #(
  parameter int HALF_CYC = 5,
  parameter int PERIODS  = 1000,
  parameter int SAMPLES  = 256,
  parameter int IDX_W    = $clog2(SAMPLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             data_strobe,
  output logic             line_window,
  output logic             sample_pulse,
  output logic [IDX_W-1:0] sample_idx,
  output logic             line_done
);
  logic high, rise, period_end, in_win, take;
  logic dv_q, dv_d, lv_q, lv_d;

  lp_phase #(.HALF_CYC(HALF_CYC)) u_phase (
    .clk(clk), .rst_n(rst_n),
    .high_o(high), .rise_o(rise), .period_end_o(period_end)
  );

  lp_frame #(.PERIODS(PERIODS), .SAMPLES(SAMPLES)) u_frame (
    .clk(clk), .rst_n(rst_n), .step_i(period_end), .in_win_o(in_win)
  );

  assign take = rise && in_win;

  lp_sampler #(.SAMPLES(SAMPLES), .IDX_W(IDX_W)) u_samp (
    .clk(clk), .rst_n(rst_n), .take_i(take),
    .sample_o(sample_pulse), .idx_o(sample_idx), .done_o(line_done)
  );

  always_comb begin
    dv_d = high;
    lv_d = in_win;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q <= 1'b0;
      lv_q <= 1'b0;
    end else begin
      dv_q <= dv_d;
      lv_q <= lv_d;
    end
  end

  assign data_strobe = dv_q;
  assign line_window = lv_q;

  // R4: a sample pulse only on a strobe rising edge inside the window
  a_r4_sample_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    sample_pulse |-> (line_window && data_strobe && !$past(data_strobe)));
  // R4: every in-window strobe rising edge carries a sample pulse
  a_r4_rise_sampled: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(data_strobe) && line_window) |-> sample_pulse);
  // R2: the window only opens together with a strobe rising edge
  a_r2_window_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_window) |-> $rose(data_strobe));
endmodule

// File: tb/line_pacer_test.sv
module line_pacer_test;
  localparam int H  = 3;
  localparam int P  = 12;
  localparam int S  = 5;
  localparam int IW = $clog2(S);
  localparam int FR = 2 * H * P;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dv, lv, smp, done;
  logic [IW-1:0] idx;

  int total = 0;
  int bad   = 0;
  bool_t_dummy_none u_none ();

  always #10 clk = ~clk;

  line_pacer #(.HALF_CYC(H), .PERIODS(P), .SAMPLES(S), .IDX_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .data_strobe(dv), .line_window(lv),
    .sample_pulse(smp), .sample_idx(idx), .line_done(done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // n = clock edges since reset release; outputs reflect frame position n-1
  task automatic check_cycle(input int n);
    int t, u, per, hb, ph, e_dv, e_lv, e_smp, e_idx, e_done;
    if (n == 0) begin
      chk("R7", "data_strobe", int'(dv), 0);
      chk("R7", "line_window", int'(lv), 0);
      chk("R7", "sample_pulse", int'(smp), 0);
      chk("R7", "sample_idx", int'(idx), 0);
      chk("R7", "line_done", int'(done), 0);
      return;
    end
    t   = n - 1;
    u   = t % FR;
    per = u / (2 * H);
    hb  = (u / H) % 2;
    ph  = u % H;
    e_dv   = (hb == 0) ? 1 : 0;
    e_lv   = (per < S) ? 1 : 0;
    e_smp  = (ph == 0 && hb == 0 && per < S) ? 1 : 0;
    if (per >= S)    e_idx = 0;
    else if (e_smp)  e_idx = per;
    else             e_idx = (per + 1) % S;
    e_done = (t >= 1 && ((t - 1) % FR) == (S - 1) * 2 * H) ? 1 : 0;
    chk("R1", "data_strobe", int'(dv), e_dv);
    chk("R2", "line_window", int'(lv), e_lv);
    chk("R4", "sample_pulse", int'(smp), e_smp);
    chk("R5", "sample_idx", int'(idx), e_idx);
    chk("R6", "line_done", int'(done), e_done);
  endtask

  task automatic sweep(input int cycles, input bit count_frames);
    int pulses;
    pulses = 0;
    @(negedge clk);
    rst_n = 1'b1;
    check_cycle(0);
    for (int n = 1; n <= cycles; n++) begin
      @(negedge clk);
      check_cycle(n);
      if (smp) pulses++;
      if (count_frames && (n % FR) == 0) begin
        chk("R3", "samples per frame", pulses, S);
        pulses = 0;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_cycle(0);
    sweep(3 * FR, 1'b1);
    // R8: reset in the middle of a frame, between clock edges
    repeat (H + 1) @(negedge clk);
    #3 rst_n = 1'b0;
    #1;
    chk("R8", "data_strobe async clear", int'(dv), 0);
    chk("R8", "line_window async clear", int'(lv), 0);
    chk("R8", "sample_idx async clear", int'(idx), 0);
    repeat (2) @(negedge clk);
    sweep(FR + FR / 2, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule

module bool_t_dummy_none;
endmodule